// File: doc/BRIEF.md
# Clocked Retriggerable One-Shot

This block turns qualified transitions on three asynchronous control lines into an output pulse whose length is a whole number of clock cycles. Two trigger lines, one active-low and one active-high, work as a pair: each can fire the pulse or hold the other off. A third line, an active-low clear, both stops the pulse and, on its release, can start one.

All three lines pass through synchronising flops before any edge is detected. The pulse length comes from a parallel input and is captured whenever a trigger is accepted. A trigger that arrives while the pulse is running restarts the full length. A short lockout window after each accepted trigger discards further triggers, so a burst of closely spaced edges cannot restart the count on every cycle. The output is driven as a true and complement pair.

Top module: `retrig_oneshot`

## Requirements
- R1: A falling edge on `fire_n` while `fire_p` is high is a trigger.
- R2: A rising edge on `fire_p` while `fire_n` is low is a trigger.
- R3: A rising edge on `clr_n` while `fire_n` is low and `fire_p` is high is a trigger.
- R4: While `fire_n` is high or `fire_p` is low, edges on the other trigger line and on `clr_n` do not start a pulse.
- R5: While the synchronised `clr_n` is low, `pulse_o` is low, `pulse_n_o` is high, and triggers are discarded. A pulse already running ends.
- R6: An accepted trigger with a nonzero `len_i` makes `pulse_o` high for exactly `len_i` cycles. `pulse_n_o` is always the complement of `pulse_o`.
- R7: An accepted trigger while `pulse_o` is high reloads the full length. Triggers spaced closer than the length keep `pulse_o` high without a gap.
- R8: A trigger evaluated on any of the `LOCK_CYC` clock edges after an accepted trigger is discarded and does not reload the count.
- R9: An accepted trigger with `len_i` equal to zero gives no pulse, and it ends a running one on the next edge.
- R10: Each control line passes through two flops. A change driven before clock edge k takes effect on `pulse_o` after edge k+2.
- R11: While `rst_n` is low at a clock edge, `pulse_o` is low and `pulse_n_o` is high after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fire_n | input | 1 | Asynchronous trigger, active on its falling edge |
| fire_p | input | 1 | Asynchronous trigger, active on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low; its rising edge can trigger |
| len_i | input | LEN_W | Pulse length in cycles, captured on an accepted trigger |
| pulse_o | output | 1 | One-shot output |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The bench uses a 16-bit length and a lockout of 3 cycles. With a 3-cycle lockout, a burst of rising edges every second cycle has every other edge fall inside the window. Edges four cycles apart all clear it. Short lengths of 2 to 10 cycles let the bench watch a pulse end, be reloaded, or be cut short by a zero length or by clear within a few dozen cycles. A behavioural reference model is compared with both outputs on every cycle.

// File: rtl/os_pkg.sv
// Shared types for the one-shot. Holds the bundle of the three control
// lines and the level each line takes when the block is idle or in reset.
package os_pkg;
    typedef struct packed {
        logic fire_n;
        logic fire_p;
        logic clr_n;
    } os_ctl_t;

    // Idle levels: both triggers inhibited, clear asserted.
    localparam os_ctl_t OS_IDLE = '{fire_n: 1'b1, fire_p: 1'b0, clr_n: 1'b0};
endpackage

// File: rtl/os_sync.sv
// Multi-stage synchroniser for a vector of asynchronous lines.
// Assumes each line changes slowly compared with the clock; all stages
// reset to RST_VAL.
module os_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Later stages settle the sampled value.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/os_trig_qual.sv
// Edge detection and trigger qualification. It compares each synchronised
// line with its value one cycle earlier and raises trig for any of the
// three valid trigger conditions. Assumes its input is already synchronous.
module os_trig_qual
    import os_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  os_ctl_t cur,
    output logic    trig
);
    os_ctl_t prev;
    logic    fall_n, rise_p, rise_clr;

    // Previous-cycle copy of the synchronised lines.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= OS_IDLE;
        else        prev <= cur;
    end

    // Edge detection and the three qualified trigger conditions.
    always_comb begin
        fall_n   = prev.fire_n & ~cur.fire_n;
        rise_p   = ~prev.fire_p & cur.fire_p;
        rise_clr = ~prev.clr_n & cur.clr_n;
        trig     = (fall_n & cur.fire_p)
                 | (rise_p & ~cur.fire_n)
                 | (rise_clr & ~cur.fire_n & cur.fire_p);
    end
endmodule

// File: rtl/os_timer.sv
// Pulse counter and retrigger lockout. An accepted trigger loads the length
// and starts the lockout window. The output is high while the count is
// nonzero. Assumes clr_n is synchronous; clear low empties both counters.
module os_timer #(
    parameter int LEN_W    = 16,
    parameter int LOCK_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             trig,
    input  logic [LEN_W-1:0] len,
    output logic             accept,
    output logic             q
);
    localparam int               LK_W   = $clog2(LOCK_CYC + 1);
    localparam logic [LK_W-1:0]  LOCK_V = LK_W'(LOCK_CYC);

    logic [LEN_W-1:0] cnt;
    logic [LK_W-1:0]  lock;

    // A trigger is taken only with clear released and the lockout expired.
    assign accept = trig & clr_n & (lock == '0);

    // Remaining pulse cycles: reload on accept, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) cnt <= '0;
        else if (accept)      cnt <= len;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Lockout window counted from each accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) lock <= '0;
        else if (accept)      lock <= LOCK_V;
        else if (lock != '0)  lock <= lock - 1'b1;
    end

    assign q = (cnt != '0);
endmodule

// File: rtl/retrig_oneshot.sv
// Top of the retriggerable one-shot: synchroniser, trigger qualifier and
// pulse timer in series. Assumes LOCK_CYC is between 1 and 15 and SYNC_STAGES
// is at least 2.
module retrig_oneshot
    import os_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int LOCK_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_n,
    input  logic             fire_p,
    input  logic             clr_n,
    input  logic [LEN_W-1:0] len_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);
    os_ctl_t raw, syn;
    logic    trig, accept, q;

    assign raw = '{fire_n: fire_n, fire_p: fire_p, clr_n: clr_n};

    os_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(OS_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    os_trig_qual u_qual (
        .clk(clk), .rst_n(rst_n), .cur(syn), .trig(trig)
    );

    os_timer #(.LEN_W(LEN_W), .LOCK_CYC(LOCK_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_n(syn.clr_n), .trig(trig),
        .len(len_i), .accept(accept), .q(q)
    );

    assign pulse_o   = q;
    assign pulse_n_o = ~q;
endmodule

// File: rtl/os_chk.sv
// Protocol checker for the one-shot, bound to the top module.
module os_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_s,
    input logic             accept,
    input logic [LEN_W-1:0] len_i,
    input logic             pulse_o,
    input logic             pulse_n_o
);
    // R6: outputs are always complementary
    a_r6_complement: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o != pulse_n_o);

    // R5: synchronised clear low forces the output low on the next cycle
    a_r5_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> !pulse_o);

    // R5: nothing is accepted while clear is low
    a_r5_no_accept_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> clr_s);

    // R6: nonzero length starts the pulse
    a_r6_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && len_i != '0) |=> pulse_o);

    // R9: zero length gives no pulse
    a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && len_i == '0) |=> !pulse_o);

    // R8: two accepts never fall on consecutive edges
    a_r8_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
endmodule

bind retrig_oneshot os_chk #(.LEN_W(LEN_W)) u_os_chk (
    .clk(clk), .rst_n(rst_n), .clr_s(syn.clr_n), .accept(accept),
    .len_i(len_i), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
);

// File: tb/tb_retrig_oneshot.sv
module tb_retrig_oneshot;
    localparam int LEN_W = 16;
    localparam int LOCK  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 1'b1, b = 1'b0, c = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic pulse_o, pulse_n_o;

    int checks = 0, fails = 0;
    string tag = "R11";
    bit done = 0;

    always #10 clk = ~clk;

    retrig_oneshot #(.LEN_W(LEN_W), .LOCK_CYC(LOCK), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .fire_n(a), .fire_p(b), .clr_n(c),
        .len_i(len), .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
    );

    // Behavioural reference: delayed copies of the inputs and integer timers.
    bit a1 = 1, a2 = 1, ap = 1, b1 = 0, b2 = 0, bp = 0, c1 = 0, c2 = 0, cp = 0;
    int m_cnt = 0, m_lock = 0;

    always @(posedge clk) begin
        bit hit;
        if (!rst_n) begin
            a1 = 1; a2 = 1; ap = 1; b1 = 0; b2 = 0; bp = 0;
            c1 = 0; c2 = 0; cp = 0; m_cnt = 0; m_lock = 0;
        end else begin
            hit = (ap && !a2 && b2) || (!bp && b2 && !a2) ||
                  (!cp && c2 && !a2 && b2);
            if (!c2) begin
                m_cnt = 0; m_lock = 0;
            end else if (hit && m_lock == 0) begin
                m_cnt = int'(len); m_lock = LOCK;
            end else begin
                if (m_cnt > 0) m_cnt--;
                if (m_lock > 0) m_lock--;
            end
            ap = a2; a2 = a1; a1 = a;
            bp = b2; b2 = b1; b1 = b;
            cp = c2; c2 = c1; c1 = c;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(pulse_o === (m_cnt != 0), tag, int'(pulse_o), int'(m_cnt != 0));
            chk(pulse_n_o === ~pulse_o, "R6", int'(pulse_n_o), int'(~pulse_o));
        end
    end

    task automatic set_in(input logic na, input logic nb, input logic nc, input int nl);
        @(negedge clk);
        a = na; b = nb; c = nc; len = LEN_W'(nl);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (pulse_o) hi++;
        end
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int hi, lows;
        tick(4);
        chk(pulse_o == 0 && pulse_n_o == 1, "R11", int'(pulse_o), 0);
        rst_n = 1'b1;

        tag = "R4";
        set_in(1, 0, 1, 0); tick(5);
        chk(pulse_o == 0, "R4 clear rise with fire_n high", int'(pulse_o), 0);
        set_in(1, 1, 1, 10); tick(5);
        chk(pulse_o == 0, "R4 fire_p rise with fire_n high", int'(pulse_o), 0);

        tag = "R1";
        set_in(0, 1, 1, 10);
        count_high(20, hi);
        chk(hi == 10, "R1 R6 pulse length", hi, 10);

        tag = "R2";
        set_in(0, 0, 1, 5); tick(4);
        chk(pulse_o == 0, "R2 falling fire_p is no trigger", int'(pulse_o), 0);
        set_in(0, 1, 1, 5);
        tick(2);
        chk(pulse_o == 0, "R10 no response after two edges", int'(pulse_o), 0);
        tick(1);
        chk(pulse_o == 1, "R10 response after third edge", int'(pulse_o), 1);
        count_high(12, hi);
        chk(hi == 4, "R2 remaining pulse cycles", hi, 4);

        tag = "R3";
        set_in(0, 1, 0, 7); tick(4);
        set_in(0, 1, 1, 7);
        count_high(15, hi);
        chk(hi == 7, "R3 clear release triggers", hi, 7);

        tag = "R4";
        set_in(1, 0, 1, 7); tick(4);
        set_in(0, 0, 1, 7);
        count_high(10, hi);
        chk(hi == 0, "R4 fire_n fall with fire_p low", hi, 0);
        set_in(1, 0, 1, 7); tick(3);
        set_in(1, 1, 1, 7);
        count_high(10, hi);
        chk(hi == 0, "R4 fire_p rise with fire_n high", hi, 0);

        tag = "R7";
        set_in(0, 1, 1, 6); tick(3);
        for (int i = 0; i < 5; i++) begin
            set_in(0, 0, 1, 6);
            chk(pulse_o == 1, "R7 held high", int'(pulse_o), 1);
            tick(2);
            chk(pulse_o == 1, "R7 held high", int'(pulse_o), 1);
            set_in(0, 1, 1, 6);
            chk(pulse_o == 1, "R7 held high", int'(pulse_o), 1);
        end
        tick(12);
        chk(pulse_o == 0, "R7 ends after last reload", int'(pulse_o), 0);

        tag = "R8";
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            set_in(0, 0, 1, 2);
            if (i > 3 && !pulse_o) lows++;
            set_in(0, 1, 1, 2);
            if (i > 3 && !pulse_o) lows++;
        end
        chk(lows > 0, "R8 burst inside lockout leaves gaps", lows, 1);
        tick(10);

        tag = "R9";
        set_in(0, 0, 1, 0); tick(2);
        set_in(0, 1, 1, 0);
        count_high(10, hi);
        chk(hi == 0, "R9 zero length", hi, 0);
        set_in(0, 0, 1, 20); tick(2);
        set_in(0, 1, 1, 20); tick(6);
        chk(pulse_o == 1, "R9 long pulse running", int'(pulse_o), 1);
        set_in(0, 0, 1, 0); tick(2);
        set_in(0, 1, 1, 0); tick(5);
        chk(pulse_o == 0, "R9 zero length ends pulse", int'(pulse_o), 0);

        tag = "R5";
        set_in(0, 0, 1, 30); tick(2);
        set_in(0, 1, 1, 30); tick(6);
        chk(pulse_o == 1, "R5 pulse running before clear", int'(pulse_o), 1);
        set_in(0, 1, 0, 30); tick(3);
        chk(pulse_o == 0 && pulse_n_o == 1, "R5 clear forces low", int'(pulse_o), 0);
        set_in(0, 0, 0, 30); tick(2);
        set_in(0, 1, 0, 30); tick(2);
        set_in(1, 1, 0, 30); tick(1);
        set_in(0, 1, 0, 30);
        count_high(8, hi);
        chk(hi == 0, "R5 triggers ignored under clear", hi, 0);
        tag = "R3";
        set_in(0, 1, 1, 4);
        count_high(10, hi);
        chk(hi == 4, "R3 clear release after clear phase", hi, 4);

        finish_run();
    end
endmodule